// File: doc/BRIEF.md
# Dual-Ratio Synchronous Clock Divider

This block derives two divided clocks from one input clock. The fast output runs at half the input rate. The slow output runs at a quarter or a sixth of the input rate, depending on a ratio-select input. Both dividers advance on the same rising edge and share one run qualifier, so wherever the two outputs switch together their edges coincide. Each output comes as a registered true copy and a separately registered complementary copy.

A freeze input stops both dividers without producing short pulses. It is captured on the falling edge of the input clock, so a freeze or release only takes effect at a rising edge that follows a full low phase. A phase-marker output goes high for one input cycle at each edge where both divided clocks rise together. Downstream logic can use it to align to the common period. The active-low asynchronous reset puts every divider in a known, mutually aligned state.

Top module: `dual_ratio_clk_div`

## Requirements
- R1: While running (freeze captured low), `div2_o` inverts on every rising edge of `clk_i`.
- R2: With `ratio_sel_i` = 0, `divb_o` has a period of 4 input cycles: high for 2 cycles, then low for 2.
- R3: With `ratio_sel_i` = 1, `divb_o` has a period of 6 input cycles: high for 3 cycles, then low for 3.
- R4: After reset is released, the first running rising edge drives `div2_o` and `divb_o` high together, and `phase_o` is high in that same cycle.
- R5: A rising edge that follows a falling edge at which `freeze_i` was captured high leaves every divided output at its current level.
- R6: `freeze_i` is sampled only on the falling edge of `clk_i`. A change made after a falling edge does not affect the rising edge that immediately follows it.
- R7: `ratio_sel_i` is sampled only on the rising edge at which `divb_o` starts a new period (goes high). Between those points it has no effect, and no high or low phase of `divb_o` is shortened.
- R8: `phase_o` is high for exactly one cycle after each rising edge at which both `div2_o` and `divb_o` go from low to high. It is low at all other times, including every cycle that is held by freeze.
- R9: `div2_n_o` is always the inverse of `div2_o`, and `divb_n_o` is always the inverse of `divb_o`.
- R10: While `rst_ni` is low, `div2_o`, `divb_o` and `phase_o` are low and the complement outputs are high, with no clock edge required.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freeze_i | input | 1 | High holds all outputs; captured on the falling clock edge |
| ratio_sel_i | input | 1 | 0 selects divide by 4, 1 selects divide by 6 for the slow output |
| div2_o | output | 1 | Divide-by-2 clock, true copy |
| div2_n_o | output | 1 | Divide-by-2 clock, complement |
| divb_o | output | 1 | Divide-by-4/6 clock, true copy |
| divb_n_o | output | 1 | Divide-by-4/6 clock, complement |
| phase_o | output | 1 | One-cycle marker at each common rising edge |

## Verification
Long free-running stretches at each fixed ratio show the divide-by-4 and divide-by-6 waveforms and the spacing of the phase marker. Ratio flips placed at random points in the slow period separate a design that samples the select input only at the start of a period from one that samples it every cycle and would cut a phase short. Random freeze bursts check that the outputs hold and that the marker clears. A directed freeze toggled between the falling and rising edges separates falling-edge capture from rising-edge capture. An asynchronous reset asserted between edges, followed by a release, checks the forced levels and the aligned first rise.

// File: rtl/dual_div_pkg.sv
`timescale 1ns/1ps
package dual_div_pkg;

  typedef struct packed {
    logic tru;
    logic cmp;
  } clk_pair_t;

  function automatic int unsigned half_len(int unsigned n);
    return n / 2;
  endfunction

endpackage

// File: rtl/div_freeze_capture.sv
`timescale 1ns/1ps
module div_freeze_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic freeze_i,
  output logic run_o
);

  logic frz_q;

  // falling-edge capture: freeze only applies after a full low phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frz_q <= 1'b0;
    else         frz_q <= freeze_i;
  end

  assign run_o = ~frz_q;

endmodule

// File: rtl/div_half_stage.sv
`timescale 1ns/1ps
module div_half_stage
  import dual_div_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  output clk_pair_t pair_o,
  output logic      rise_o
);

  logic q_q;
  logic qn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q  <= 1'b0;
      qn_q <= 1'b1;
    end else if (run_i) begin
      q_q  <= ~q_q;
      qn_q <= q_q;
    end
  end

  assign rise_o     = run_i & ~q_q;
  assign pair_o.tru = q_q;
  assign pair_o.cmp = qn_q;

endmodule

// File: rtl/div_sel_stage.sv
`timescale 1ns/1ps
module div_sel_stage
  import dual_div_pkg::*;
#(
  parameter int unsigned DIV_LO = 4,
  parameter int unsigned DIV_HI = 6
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  logic      sel_hi_i,
  output clk_pair_t pair_o,
  output logic      rise_o
);

  localparam int unsigned CNT_W = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(DIV_LO - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(DIV_HI - 1);
  localparam logic [CNT_W-1:0] HALF_LO = CNT_W'(half_len(DIV_LO));
  localparam logic [CNT_W-1:0] HALF_HI = CNT_W'(half_len(DIV_HI));

  logic [CNT_W-1:0] cnt_q, cnt_d, last_c, half_c;
  logic             hi_q, eff_hi;
  logic             q_q, qn_q, q_d;
  logic             at_start;

  assign at_start = (cnt_q == '0);

  generate
    if (DIV_LO == DIV_HI) begin : g_fixed
      assign eff_hi = 1'b0;
    end else begin : g_sel
      // ratio is only reloaded at the start of a period
      assign eff_hi = at_start ? sel_hi_i : hi_q;
    end
  endgenerate

  assign last_c = eff_hi ? LAST_HI : LAST_LO;
  assign half_c = eff_hi ? HALF_HI : HALF_LO;
  assign cnt_d  = (cnt_q == last_c) ? '0 : cnt_q + 1'b1;
  assign q_d    = (cnt_d != '0) && (cnt_d <= half_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
      q_q   <= 1'b0;
      qn_q  <= 1'b1;
    end else if (run_i) begin
      cnt_q <= cnt_d;
      hi_q  <= eff_hi;
      q_q   <= q_d;
      qn_q  <= ~q_d;
    end
  end

  assign rise_o     = run_i & at_start;
  assign pair_o.tru = q_q;
  assign pair_o.cmp = qn_q;

endmodule

// File: rtl/div_phase_mark.sv
`timescale 1ns/1ps
module div_phase_mark (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_a_i,
  input  logic rise_b_i,
  output logic mark_o
);

  logic mark_q;

  // rise inputs already carry the run qualifier, so freeze clears the mark
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mark_q <= 1'b0;
    else         mark_q <= rise_a_i & rise_b_i;
  end

  assign mark_o = mark_q;

endmodule

// File: rtl/dual_ratio_clk_div.sv
`timescale 1ns/1ps
module dual_ratio_clk_div
  import dual_div_pkg::*;
#(
  parameter int unsigned DIV_LO = 4,
  parameter int unsigned DIV_HI = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic freeze_i,
  input  logic ratio_sel_i,
  output logic div2_o,
  output logic div2_n_o,
  output logic divb_o,
  output logic divb_n_o,
  output logic phase_o
);

  logic      run;
  logic      rise_a, rise_b;
  clk_pair_t pair_a, pair_b;

  div_freeze_capture u_frz (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .freeze_i (freeze_i),
    .run_o    (run)
  );

  div_half_stage u_div_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .pair_o (pair_a),
    .rise_o (rise_a)
  );

  div_sel_stage #(
    .DIV_LO (DIV_LO),
    .DIV_HI (DIV_HI)
  ) u_div_b (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .sel_hi_i (ratio_sel_i),
    .pair_o   (pair_b),
    .rise_o   (rise_b)
  );

  div_phase_mark u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_a_i (rise_a),
    .rise_b_i (rise_b),
    .mark_o   (phase_o)
  );

  assign div2_o   = pair_a.tru;
  assign div2_n_o = pair_a.cmp;
  assign divb_o   = pair_b.tru;
  assign divb_n_o = pair_b.cmp;

endmodule

// File: rtl/dual_ratio_clk_div_chk.sv
`timescale 1ns/1ps
module dual_ratio_clk_div_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic freeze_i,
  input logic ratio_sel_i,
  input logic div2_o,
  input logic div2_n_o,
  input logic divb_o,
  input logic divb_n_o,
  input logic phase_o
);

  logic frz_seen;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frz_seen <= 1'b0;
    else         frz_seen <= freeze_i;
  end

  p_div2_toggle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frz_seen |=> (div2_o != $past(div2_o)));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_seen |=> ($stable(div2_o) && $stable(divb_o)));

  p_no_short_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(divb_o) |=> divb_o);

  p_no_short_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(divb_o) |=> !divb_o);

  p_phase_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o |-> (div2_o && divb_o && !$past(div2_o) && !$past(divb_o)));

  p_phase_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o |=> !phase_o);

  p_phase_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_seen |=> !phase_o);

  p_compl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div2_n_o == !div2_o) && (divb_n_o == !divb_o));

  p_reset_r10: assert property (@(posedge clk_i)
    !rst_ni |-> (!div2_o && !divb_o && !phase_o && div2_n_o && divb_n_o));

endmodule

bind dual_ratio_clk_div dual_ratio_clk_div_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .freeze_i    (freeze_i),
  .ratio_sel_i (ratio_sel_i),
  .div2_o      (div2_o),
  .div2_n_o    (div2_n_o),
  .divb_o      (divb_o),
  .divb_n_o    (divb_n_o),
  .phase_o     (phase_o)
);

// File: tb/dual_ratio_clk_div_bench.sv
`timescale 1ns/1ps
module dual_ratio_clk_div_bench;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic freeze_i;
  logic ratio_sel_i;
  logic div2_o, div2_n_o, divb_o, divb_n_o, phase_o;

  int n_chk = 0;
  int n_err = 0;

  // model state
  logic m_frz;
  logic m_a, m_b, m_ph;
  int   m_p, m_n;

  always #2 clk_i = ~clk_i;

  dual_ratio_clk_div u_dual_ratio_clk_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .freeze_i    (freeze_i),
    .ratio_sel_i (ratio_sel_i),
    .div2_o      (div2_o),
    .div2_n_o    (div2_n_o),
    .divb_o      (divb_o),
    .divb_n_o    (divb_n_o),
    .phase_o     (phase_o)
  );

  always @(negedge clk_i) begin
    if (!rst_ni) m_frz <= 1'b0;
    else         m_frz <= freeze_i;
  end

  function automatic logic exp_slow(int p, int n);
    return (p >= 1) && (p <= n / 2);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at %0t: got %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_a = 1'b0; m_b = 1'b0; m_ph = 1'b0; m_p = 0; m_n = 4;
  endtask

  task automatic check_all(string tag_a, string tag_b);
    string tb_ph;
    tb_ph = m_frz ? "R8 frozen" : "R8";
    chk(tag_a, div2_o, m_a);
    chk(tag_b, divb_o, m_b);
    chk("R9 div2_n", div2_n_o, !m_a);
    chk("R9 divb_n", divb_n_o, !m_b);
    chk(tb_ph, phase_o, m_ph);
  endtask

  // one rising edge: model advance, then compare after the edge
  task automatic step();
    string ta, tb;
    logic  ph;
    @(posedge clk_i);
    #1;
    if (!rst_ni) begin
      model_reset();
      ta = "R10"; tb = "R10";
    end else if (m_frz) begin
      m_ph = 1'b0;
      ta = "R5"; tb = "R5";
    end else begin
      ph = !m_a && (m_p == 0);
      if (m_p == 0) m_n = ratio_sel_i ? 6 : 4;
      tb = (m_n == 6) ? "R3" : "R2";
      if ((m_p != 0) && (ratio_sel_i != (m_n == 6))) tb = "R7";
      m_p  = (m_p == m_n - 1) ? 0 : m_p + 1;
      m_a  = !m_a;
      m_b  = exp_slow(m_p, m_n);
      m_ph = ph;
      ta = "R1";
    end
    check_all(ta, tb);
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL R1: watchdog expired, got running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_ni = 1'b1; freeze_i = 1'b0; ratio_sel_i = 1'b0;
    model_reset();
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R10 div2", div2_o, 1'b0);
    chk("R10 divb", divb_o, 1'b0);
    chk("R10 phase", phase_o, 1'b0);
    chk("R10 div2_n", div2_n_o, 1'b1);
    step();
    step();
    rst_ni = 1'b1;

    // R4: first edge after release rises both and marks phase
    step();
    chk("R4 div2", div2_o, 1'b1);
    chk("R4 divb", divb_o, 1'b1);
    chk("R4 phase", phase_o, 1'b1);
    for (int i = 0; i < 23; i++) step();

    ratio_sel_i = 1'b1;
    for (int i = 0; i < 30; i++) step();

    // R7: flip ratio inside a period
    step();
    ratio_sel_i = 1'b0;
    for (int i = 0; i < 13; i++) step();
    ratio_sel_i = 1'b1;
    step();
    ratio_sel_i = 1'b0;
    for (int i = 0; i < 12; i++) step();

    // R6: freeze raised after the falling edge does not hit the next rise
    begin
      logic a_before;
      a_before = div2_o;
      @(negedge clk_i);
      #1 freeze_i = 1'b1;
      step();
      chk("R6 late freeze ignored", div2_o, !a_before);
      a_before = div2_o;
      step();
      chk("R6 freeze applied", div2_o, a_before);
      @(negedge clk_i);
      #1 freeze_i = 1'b0;
      step();
      chk("R6 late release ignored", div2_o, a_before);
      step();
      chk("R6 release applied", div2_o, !a_before);
    end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      step();
      freeze_i = ($urandom_range(5) == 0);
      if ($urandom_range(19) == 0) ratio_sel_i = ~ratio_sel_i;
    end
    freeze_i = 1'b0;
    for (int i = 0; i < 4; i++) step();

    // R10: asynchronous reset between edges
    rst_ni = 1'b0;
    #0.5;
    chk("R10 async div2", div2_o, 1'b0);
    chk("R10 async divb", divb_o, 1'b0);
    chk("R10 async phase", phase_o, 1'b0);
    chk("R10 async divb_n", divb_n_o, 1'b1);
    model_reset();
    step();
    rst_ni = 1'b1;
    ratio_sel_i = 1'b1;
    step();
    chk("R4 phase after rerelease", phase_o, 1'b1);
    for (int i = 0; i < 20; i++) step();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule